// File: doc/BRIEF.md
# Watchdog Timer with Alternating Clear Protocol

This block supervises a small processor core. It counts ticks from one of two sources and, if software fails to service it in time, asks for a reset. A static input picks the source. One choice is an enable tick from a dedicated slow oscillator. The other is an instruction-clock tick made inside the block, one for every eight system clocks. Each tick goes through a fixed binary stage of `FIX_BITS` bits (256 ticks by default) and then through a prescaler whose ratio comes from a 3-bit code.

Software services the watchdog through decoded clear strobes. A static mode input decides which strobes count. In single mode one strobe is enough. In paired mode two different strobes must be used in alternation, and repeating the same one does nothing. A halt strobe and the asynchronous external reset also restart the count.

When the count runs out in normal operation, the block sends a one-cycle full-reset request and sets a sticky time-out flag. When it runs out while the core is powered down, the block asks only for a program-counter and stack reset.

Top module: `wdt_core`

## Requirements
- R1: In single mode (`pair_mode_i`=0), a `clr_i` strobe restarts the count. The first request then appears after exactly 2^`FIX_BITS` × 2^code ticks, where the tick on which a clear is taken is not counted.
- R2: Prescaler code n on `ws_i` divides by 2^n: code 0 gives 1:1 and code 7 gives 1:128.
- R3: With `src_sel_i`=1, one tick occurs for every `SYS_DIV` (8) system clocks. The divider restarts whenever the watchdog count restarts.
- R4: In paired mode, the first of `clr1_i`/`clr2_i` seen from the idle state only arms and does not clear. After that, the other strobe clears, and repeating the last strobe is ignored. `clr_i` is ignored in paired mode, and `clr1_i`/`clr2_i` are ignored in single mode.
- R5: A time-out while `pdn_i`=0 drives `full_rst_o` high for exactly one cycle, in the cycle after the last tick, and sets `to_o`.
- R6: A time-out while `pdn_i`=1 drives `pc_rst_o` high for one cycle. It leaves `full_rst_o` low and `to_o` unchanged.
- R7: `halt_i` restarts the count. `rst_ni` low at once clears the count, `to_o` and the paired-clear state.
- R8: With `wdt_en_i`=0 nothing counts, no request is made, and clear strobes have no effect, so `to_o` keeps its value.
- R9: With the instruction-clock source and `pdn_i`=1 the count is frozen. The oscillator source keeps counting in power-down.
- R10: `to_o` stays set until a valid software clear or an external reset.
- R11: A time-out returns the paired-clear state to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low external reset |
| wdt_en_i | input | 1 | Watchdog enable option |
| src_sel_i | input | 1 | Tick source: 0 oscillator tick, 1 instruction clock |
| osc_tick_i | input | 1 | Enable tick from the slow oscillator |
| pair_mode_i | input | 1 | Clear mode: 0 single strobe, 1 alternating pair |
| ws_i | input | 3 | Prescaler code |
| clr_i | input | 1 | Single-clear strobe |
| clr1_i | input | 1 | First paired-clear strobe |
| clr2_i | input | 1 | Second paired-clear strobe |
| halt_i | input | 1 | Halt strobe |
| pdn_i | input | 1 | Core is powered down |
| full_rst_o | output | 1 | Full device reset request pulse |
| pc_rst_o | output | 1 | Program counter and stack reset request pulse |
| to_o | output | 1 | Sticky time-out flag |

## Verification
The bench builds the block with `FIX_BITS`=2 and the default `SYS_DIV`=8. The longest prescaler code then takes only 512 oscillator ticks, and the instruction-clock path 32 system clocks at code 0. Exact time-out latencies can therefore be measured for codes 0, 3 and 7, and for both sources. The short period also leaves room to walk through every paired-clear ordering and the power-down and disabled cases, with each outcome seen as a changed time-out latency.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [1:0] {
    PAIR_IDLE  = 2'd0,
    PAIR_HAVE1 = 2'd1,
    PAIR_HAVE2 = 2'd2
  } pair_st_e;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int unsigned SYS_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic src_instr_i,
  input  logic osc_tick_i,
  input  logic pdn_i,
  input  logic sync_clr_i,
  output logic tick_o
);
  localparam int unsigned DW = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(SYS_DIV - 1);

  logic [DW-1:0] div_q;
  logic          run;
  logic          wrap;

  // system clock is stopped in power-down, so the divider freezes
  assign run  = en_i & src_instr_i & ~pdn_i;
  assign wrap = run & (div_q == DIV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         div_q <= '0;
    else if (sync_clr_i) div_q <= '0;
    else if (run)        div_q <= wrap ? '0 : div_q + 1'b1;
  end

  assign tick_o = en_i & (src_instr_i ? wrap : osc_tick_i);

  AST_INSTR_FROZEN_PDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_instr_i && pdn_i) |=> $stable(div_q)); // R9
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned FIX_BITS = 8,
  parameter int unsigned SEL_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] ws_i,
  output logic             ovf_o
);
  localparam int unsigned PSC_W = (1 << SEL_W) - 1;

  logic [FIX_BITS-1:0] fix_q;
  logic [PSC_W-1:0]    psc_q;
  logic [PSC_W-1:0]    mask;
  logic                fix_wrap;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PSC_W; i++) mask[i] = (i < int'(ws_i));
  end

  assign fix_wrap = tick_i & (&fix_q);
  assign ovf_o    = fix_wrap & ((psc_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fix_q <= '0;
      psc_q <= '0;
    end else if (clr_i || ovf_o) begin
      fix_q <= '0;
      psc_q <= '0;
    end else if (tick_i) begin
      fix_q <= fix_q + 1'b1;
      if (fix_wrap) psc_q <= psc_q + 1'b1;
    end
  end

  AST_CLR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (fix_q == '0 && psc_q == '0)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> ($stable(fix_q) && $stable(psc_q))); // R8
endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl
  import wdt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pair_mode_i,
  input  logic clr_i,
  input  logic clr1_i,
  input  logic clr2_i,
  input  logic tmo_i,
  output logic clr_ok_o
);
  pair_st_e st_q, st_d;
  logic     only1, only2;

  // decoded strobes are exclusive; both at once is treated as no strobe
  assign only1 = clr1_i & ~clr2_i;
  assign only2 = clr2_i & ~clr1_i;

  always_comb begin
    st_d     = st_q;
    clr_ok_o = 1'b0;
    if (en_i) begin
      if (!pair_mode_i) begin
        clr_ok_o = clr_i;
      end else begin
        unique case (st_q)
          PAIR_IDLE: begin
            if (only1)      st_d = PAIR_HAVE1;
            else if (only2) st_d = PAIR_HAVE2;
          end
          PAIR_HAVE1: if (only2) begin
            clr_ok_o = 1'b1;
            st_d     = PAIR_HAVE2;
          end
          PAIR_HAVE2: if (only1) begin
            clr_ok_o = 1'b1;
            st_d     = PAIR_HAVE1;
          end
          default: st_d = PAIR_IDLE;
        endcase
      end
    end
    if (tmo_i) st_d = PAIR_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PAIR_IDLE;
    else         st_q <= st_d;
  end

  AST_PAIR_NO_REPEAT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_mode_i && clr_ok_o && only1) |=> !(pair_mode_i && clr_ok_o && only1)); // R4
  AST_PAIR_NO_REPEAT2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_mode_i && clr_ok_o && only2) |=> !(pair_mode_i && clr_ok_o && only2)); // R4
  AST_TMO_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> (st_q == PAIR_IDLE)); // R11
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned FIX_BITS = 8,
  parameter int unsigned SYS_DIV  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wdt_en_i,
  input  logic             src_sel_i,
  input  logic             osc_tick_i,
  input  logic             pair_mode_i,
  input  logic [SEL_W-1:0] ws_i,
  input  logic             clr_i,
  input  logic             clr1_i,
  input  logic             clr2_i,
  input  logic             halt_i,
  input  logic             pdn_i,
  output logic             full_rst_o,
  output logic             pc_rst_o,
  output logic             to_o
);
  logic tick, clr_ok, sync_clr, ovf, tmo;
  logic full_q, pc_q, to_q;

  assign sync_clr = clr_ok | halt_i;
  assign tmo      = ovf & ~sync_clr;

  wdt_tick_gen #(.SYS_DIV(SYS_DIV)) u_tick (
    .clk_i, .rst_ni,
    .en_i        (wdt_en_i),
    .src_instr_i (src_sel_i),
    .osc_tick_i,
    .pdn_i,
    .sync_clr_i  (sync_clr),
    .tick_o      (tick)
  );

  wdt_counter #(.FIX_BITS(FIX_BITS), .SEL_W(SEL_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i (tick),
    .clr_i  (sync_clr),
    .ws_i,
    .ovf_o  (ovf)
  );

  wdt_clear_ctl u_clr (
    .clk_i, .rst_ni,
    .en_i     (wdt_en_i),
    .pair_mode_i,
    .clr_i, .clr1_i, .clr2_i,
    .tmo_i    (tmo),
    .clr_ok_o (clr_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      pc_q   <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      full_q <= tmo & ~pdn_i;
      pc_q   <= tmo & pdn_i;
      if (clr_ok)              to_q <= 1'b0;
      else if (tmo && !pdn_i)  to_q <= 1'b1;
    end
  end

  assign full_rst_o = full_q;
  assign pc_rst_o   = pc_q;
  assign to_o       = to_q;

  AST_ONE_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_rst_o && pc_rst_o)); // R6
  AST_FULL_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rst_o |-> to_o); // R5
  AST_FULL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rst_o |=> !full_rst_o); // R5
  AST_PC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_rst_o |=> !pc_rst_o); // R6
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_en_i |=> (!full_rst_o && !pc_rst_o)); // R8
  AST_TO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_o && !clr_ok) |=> to_o); // R10
endmodule

// File: tb/wdt_core_bench.sv
module wdt_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, src = 1'b0, osc = 1'b1, pair = 1'b0, pdn = 1'b0;
  logic [2:0] ws = 3'd0;
  logic clr = 0, clr1 = 0, clr2 = 0, halt = 0;
  logic full_rst, pc_rst, to;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdt_core #(.FIX_BITS(2), .SYS_DIV(8)) u_wdt_core (
    .clk_i(clk), .rst_ni(rst_n), .wdt_en_i(en), .src_sel_i(src),
    .osc_tick_i(osc), .pair_mode_i(pair), .ws_i(ws), .clr_i(clr),
    .clr1_i(clr1), .clr2_i(clr2), .halt_i(halt), .pdn_i(pdn),
    .full_rst_o(full_rst), .pc_rst_o(pc_rst), .to_o(to)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // 0 clr, 1 clr1, 2 clr2, 3 halt; held for one edge
  task automatic strobe(int s);
    clr = (s == 0); clr1 = (s == 1); clr2 = (s == 2); halt = (s == 3);
    cyc();
    clr = 0; clr1 = 0; clr2 = 0; halt = 0;
  endtask

  task automatic measure(output int k);
    k = 0;
    do begin
      cyc();
      k++;
    end while (!(full_rst || pc_rst) && k < 5000);
  endtask

  task automatic quiet(int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (full_rst || pc_rst) hits++;
    end
  endtask

  task automatic t_reset_state();
    chk("R7 reset full", full_rst, 0);
    chk("R7 reset pc", pc_rst, 0);
    chk("R7 reset to", to, 0);
  endtask

  task automatic t_single();
    int k;
    pair = 0; src = 0;
    ws = 3'd0; strobe(0); measure(k);
    chk("R1 period code0", k, 4);
    chk("R5 full pulse", full_rst, 1);
    chk("R5 to set", to, 1);
    cyc();
    chk("R5 pulse one cycle", full_rst, 0);
    ws = 3'd3; strobe(0); measure(k);
    chk("R2 period code3", k, 32);
    ws = 3'd7; strobe(0); measure(k);
    chk("R2 period code7", k, 512);
    ws = 3'd0;
  endtask

  task automatic t_to_clear();
    chk("R10 to held", to, 1);
    strobe(0);
    chk("R10 to cleared by clear", to, 0);
  endtask

  task automatic t_instr();
    int k;
    src = 1; ws = 3'd0; strobe(0); measure(k);
    chk("R3 instr period", k, 32);
    src = 0;
  endtask

  task automatic t_pair();
    int k;
    pair = 1; ws = 3'd2;
    strobe(3);
    repeat (5) cyc();
    strobe(1); measure(k);
    chk("R4 first strobe only arms", k, 10);
    strobe(3); strobe(1); strobe(1); strobe(0); strobe(2); measure(k);
    chk("R4 repeat and single ignored, pair clears", k, 16);
    strobe(3); strobe(1); strobe(2);
    repeat (3) cyc();
    strobe(2); measure(k);
    chk("R4 repeated clr2 ignored", k, 12);
    strobe(3); strobe(1); strobe(2); strobe(1); measure(k);
    chk("R4 alternation clears", k, 16);
    strobe(3); strobe(2); measure(k);
    chk("R11 idle after timeout", k, 15);
    pair = 0;
    strobe(0);
    repeat (3) cyc();
    strobe(1); strobe(2); measure(k);
    chk("R4 pair strobes ignored in single", k, 11);
    ws = 3'd0;
  endtask

  task automatic t_pdn();
    int k, h;
    pair = 0; pdn = 1;
    strobe(0); measure(k);
    chk("R9 osc counts in pdn", k, 4);
    chk("R6 pc pulse", pc_rst, 1);
    chk("R6 no full", full_rst, 0);
    chk("R6 to unchanged", to, 0);
    src = 1; strobe(0); quiet(200, h);
    chk("R9 instr frozen in pdn", h, 0);
    pdn = 0; measure(k);
    chk("R9 resumes after pdn", k, 32);
    src = 0;
  endtask

  task automatic t_disabled();
    int k, h;
    strobe(0); measure(k);
    chk("R5 to set again", to, 1);
    en = 0;
    strobe(0);
    chk("R8 clr no effect", to, 1);
    pair = 1; strobe(1); strobe(2); strobe(1);
    chk("R8 pair no effect", to, 1);
    pair = 0;
    quiet(100, h);
    chk("R8 no requests", h, 0);
    en = 1; measure(k);
    chk("R8 count held", k, 4);
  endtask

  task automatic t_halt_rst();
    int k;
    strobe(0);
    repeat (3) cyc();
    strobe(3); measure(k);
    chk("R7 halt restarts", k, 4);
    pair = 1; strobe(3); strobe(1);
    rst_n = 0; #1;
    chk("R7 reset clears to", to, 0);
    @(negedge clk);
    rst_n = 1;
    strobe(2); measure(k);
    chk("R7 reset clears pair state", k, 3);
    pair = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1;
    t_single();
    t_to_clear();
    t_instr();
    t_pair();
    t_pdn();
    t_disabled();
    t_halt_rst();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule